// File: doc/BRIEF.md
# Thermal Sensor Channel Sequencer

This block is the register-controlled front end of a multi-channel temperature sensor with one internal source and up to `N_EXT` external sources. Software programs a control word that runs or halts measurement, holds the sensor in reset, enables it, and picks the source through a mode field and a channel field. A second word selects how many samples are averaged. A status word returns the latest averaged 10-bit reading together with a valid flag.

Source changes are accepted only while measurement is halted. Every real change of source drops the valid flag and reloads a settling timer of `SETTLE_CYC` running cycles. Only after that timer expires does the block start issuing one-cycle sample requests. These come every `TICK_BASE * 2^osr` cycles, and the block captures `smp_data_i` on each one. Once a full averaging window has been collected, the block publishes the result and raises valid. The analog sensor is modelled by the stimulus on `smp_data_i`.

Top module: `thermal_seq`

## Requirements
- R1: After reset all three registers read as zero, `valid_o` and `smp_req_o` are low and `src_o` is 0 (internal).
- R2: Word address 0 is control: start bit 0, sensor reset bit 1, enable bit 2, average bypass bit 6, channel bits 16:13, rate bits 25:24, mode bits 31:30. These fields read back and all other bits read 0. Address 1 holds the average exponent in bits 2:0. Address 2 is status, with the sample in bits 9:0 and valid in bit 10.
- R3: The source encoding works as follows. Mode 2 selects external source `chan+1` (`src_o = chan+1`). Any other mode selects the internal source (`src_o = 0`). A mode-2 write with `chan >= N_EXT` leaves mode, channel and source unchanged.
- R4: While start is set, a control write keeps mode, channel and `src_o` unchanged and still updates the other fields.
- R5: A write that changes `src_o` clears `valid_o` in the following cycle.
- R6: With P = `TICK_BASE*2^rate` and N = 2^avg (N = 1 when bypass is set), after a source change `valid_o` is first seen high exactly `SETTLE_CYC + N*P` cycles after the cycle in which start is written.
- R7: The published sample is the floor of the mean of the N captured samples. With bypass set, it is the single captured sample.
- R8: `smp_req_o` pulses for one cycle per period, only while running and settled. Exactly N pulses come before valid rises, and `smp_data_i` is captured in each pulse cycle.
- R9: While the reset bit is set or enable is clear, `valid_o` drops and no requests are issued. Releasing the sensor restarts the full settling and averaging latency.
- R10: A write to an equal source, even with a different mode encoding, keeps `valid_o` high and does not restart settling. After a restart, the first request comes P-1 cycles after the start write.
- R11: Clearing start stops requests and holds `valid_o` and the sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_i | input | 1 | Register write strobe |
| addr_i | input | ADDR_W | Word address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i` (combinational) |
| smp_data_i | input | 10 | Sensor conversion result |
| smp_req_o | output | 1 | Sample capture strobe |
| src_o | output | SRC_W | Selected source, 0 internal, k external k |
| valid_o | output | 1 | Status valid flag |

## Verification
The assertions assume that software only moves the source through the halt, reselect and restart order. Writes made while running are expected to be rejected, not to corrupt the selection. The assertions also assume that `N_EXT` stays below 16, so that the source index fits its width. The stimulus always clears start before it writes a new source. It writes while running only to probe rejection, and it keeps channels within or just past the configured range. `smp_data_i` changes only after the clock edge that consumed a request, so every capture sees a stable value.

// File: rtl/thsq_pkg.sv
package thsq_pkg;
  localparam int SMP_W   = 10;
  localparam int AVG_W   = 3;
  localparam int ACC_W   = SMP_W + (1 << AVG_W) - 1;
  localparam int CNT_W   = (1 << AVG_W) - 1;

  localparam int REG_CTRL = 0;
  localparam int REG_AVG  = 1;
  localparam int REG_STAT = 2;

  localparam int B_START  = 0;
  localparam int B_SRST   = 1;
  localparam int B_EN     = 2;
  localparam int B_BYP    = 6;
  localparam int B_CHAN   = 13;
  localparam int B_RATE   = 24;
  localparam int B_MODE   = 30;
  localparam int B_VALID  = 10;

  localparam logic [1:0] MODE_EXT = 2'd2;

  typedef struct packed {
    logic [1:0] mode;
    logic [1:0] rate;
    logic [3:0] chan;
    logic       bypass;
    logic       en;
    logic       srst;
    logic       start;
  } ctrl_t;
endpackage

// File: rtl/thsq_regs.sv
module thsq_regs
  import thsq_pkg::*;
#(
  parameter int N_EXT  = 4,
  parameter int ADDR_W = 2,
  parameter int SRC_W  = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  input  logic              valid_i,
  input  logic [SMP_W-1:0]  sample_i,
  output logic [31:0]       rdata_o,
  output ctrl_t             ctrl_o,
  output logic [AVG_W-1:0]  avg_o,
  output logic [SRC_W-1:0]  src_o,
  output logic              src_chg_o
);
  ctrl_t              ctrl_q;
  logic [AVG_W-1:0]   avg_q;
  logic [SRC_W-1:0]   src_q;
  logic               wr_ctrl, wr_avg;
  logic [1:0]         w_mode;
  logic [3:0]         w_chan;
  logic               w_ext, w_ok, src_take;
  logic [SRC_W-1:0]   w_src;

  assign wr_ctrl = wr_i && (addr_i == ADDR_W'(REG_CTRL));
  assign wr_avg  = wr_i && (addr_i == ADDR_W'(REG_AVG));
  assign w_mode  = wdata_i[B_MODE +: 2];
  assign w_chan  = wdata_i[B_CHAN +: 4];
  assign w_ext   = (w_mode == MODE_EXT);
  assign w_ok    = !w_ext || ({1'b0, w_chan} < 5'(N_EXT));
  assign w_src   = w_ext ? (w_chan[SRC_W-1:0] + SRC_W'(1)) : '0;
  // source fields only move while halted
  assign src_take  = wr_ctrl && !ctrl_q.start && w_ok;
  assign src_chg_o = src_take && (w_src != src_q);

  logic unused_wbits;
  assign unused_wbits = ^{wdata_i[5:3], wdata_i[12:7], wdata_i[23:17], wdata_i[29:26]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      avg_q  <= '0;
      src_q  <= '0;
    end else begin
      if (wr_ctrl) begin
        ctrl_q.start  <= wdata_i[B_START];
        ctrl_q.srst   <= wdata_i[B_SRST];
        ctrl_q.en     <= wdata_i[B_EN];
        ctrl_q.bypass <= wdata_i[B_BYP];
        ctrl_q.rate   <= wdata_i[B_RATE +: 2];
        if (src_take) begin
          ctrl_q.mode <= w_mode;
          ctrl_q.chan <= w_chan;
          src_q       <= w_src;
        end
      end
      if (wr_avg) avg_q <= wdata_i[AVG_W-1:0];
    end
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      ADDR_W'(REG_CTRL): begin
        rdata_o[B_START]     = ctrl_q.start;
        rdata_o[B_SRST]      = ctrl_q.srst;
        rdata_o[B_EN]        = ctrl_q.en;
        rdata_o[B_BYP]       = ctrl_q.bypass;
        rdata_o[B_CHAN +: 4] = ctrl_q.chan;
        rdata_o[B_RATE +: 2] = ctrl_q.rate;
        rdata_o[B_MODE +: 2] = ctrl_q.mode;
      end
      ADDR_W'(REG_AVG):  rdata_o[AVG_W-1:0] = avg_q;
      ADDR_W'(REG_STAT): begin
        rdata_o[SMP_W-1:0] = sample_i;
        rdata_o[B_VALID]   = valid_i;
      end
      default: rdata_o = '0;
    endcase
  end

  assign ctrl_o = ctrl_q;
  assign avg_o  = avg_q;
  assign src_o  = src_q;
endmodule

// File: rtl/thsq_pace.sv
module thsq_pace #(
  parameter int SETTLE_CYC = 1500000,
  parameter int TICK_BASE  = 25000
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       active_i,
  input  logic       run_i,
  input  logic       reload_i,
  input  logic [1:0] rate_i,
  output logic       settled_o,
  output logic       tick_o
);
  localparam int SET_W = $clog2(SETTLE_CYC + 1);
  localparam int TCK_W = $clog2(TICK_BASE * 8 + 1);

  logic [SET_W-1:0] settle_q;
  logic [TCK_W-1:0] tcnt_q, period;

  assign period    = TCK_W'(TICK_BASE) << rate_i;
  assign settled_o = (settle_q == '0);
  assign tick_o    = run_i && settled_o && (tcnt_q == period - TCK_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   settle_q <= SET_W'(SETTLE_CYC);
    else if (reload_i || !active_i) settle_q <= SET_W'(SETTLE_CYC);
    else if (run_i && !settled_o)  settle_q <= settle_q - SET_W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                  tcnt_q <= '0;
    else if (!run_i || reload_i || !settled_o || tick_o) tcnt_q <= '0;
    else                                          tcnt_q <= tcnt_q + TCK_W'(1);
  end
endmodule

// File: rtl/thsq_avg.sv
module thsq_avg
  import thsq_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             tick_i,
  input  logic [AVG_W-1:0] log_i,
  input  logic [SMP_W-1:0] smp_i,
  output logic             valid_o,
  output logic [SMP_W-1:0] sample_o
);
  logic [ACC_W-1:0] acc_q, sum, mean;
  logic [CNT_W-1:0] n_q;
  logic [CNT_W:0]   n_lim;
  logic             last;

  assign sum   = acc_q + ACC_W'(smp_i);
  assign mean  = sum >> log_i;
  assign n_lim = (CNT_W+1)'(1) << log_i;
  assign last  = ({1'b0, n_q} == n_lim - (CNT_W+1)'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q    <= '0;
      n_q      <= '0;
      valid_o  <= 1'b0;
      sample_o <= '0;
    end else if (clear_i) begin
      acc_q   <= '0;
      n_q     <= '0;
      valid_o <= 1'b0;
    end else if (tick_i) begin
      if (last) begin
        acc_q    <= '0;
        n_q      <= '0;
        valid_o  <= 1'b1;
        sample_o <= mean[SMP_W-1:0];
      end else begin
        acc_q <= sum;
        n_q   <= n_q + CNT_W'(1);
      end
    end
  end
endmodule

// File: rtl/thermal_seq.sv
module thermal_seq
  import thsq_pkg::*;
#(
  parameter int N_EXT      = 4,
  parameter int SETTLE_CYC = 1500000,
  parameter int TICK_BASE  = 25000,
  parameter int ADDR_W     = 2,
  parameter int SRC_W      = $clog2(N_EXT + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  input  logic [SMP_W-1:0]  smp_data_i,
  output logic              smp_req_o,
  output logic [SRC_W-1:0]  src_o,
  output logic              valid_o
);
  ctrl_t            ctrl;
  logic [AVG_W-1:0] avg;
  logic             src_chg, active, run, settled;
  logic [SMP_W-1:0] sample;

  assign active = ctrl.en && !ctrl.srst;
  assign run    = active && ctrl.start;

  thsq_regs #(.N_EXT(N_EXT), .ADDR_W(ADDR_W), .SRC_W(SRC_W)) u_regs (
    .clk_i, .rst_ni, .wr_i, .addr_i, .wdata_i,
    .valid_i(valid_o), .sample_i(sample), .rdata_o,
    .ctrl_o(ctrl), .avg_o(avg), .src_o, .src_chg_o(src_chg)
  );

  thsq_pace #(.SETTLE_CYC(SETTLE_CYC), .TICK_BASE(TICK_BASE)) u_pace (
    .clk_i, .rst_ni, .active_i(active), .run_i(run), .reload_i(src_chg),
    .rate_i(ctrl.rate), .settled_o(settled), .tick_o(smp_req_o)
  );

  thsq_avg u_avg (
    .clk_i, .rst_ni, .clear_i(src_chg || !active), .tick_i(smp_req_o),
    .log_i(ctrl.bypass ? '0 : avg), .smp_i(smp_data_i),
    .valid_o, .sample_o(sample)
  );
endmodule

// File: rtl/thermal_seq_chk.sv
module thermal_seq_chk #(
  parameter int N_EXT = 4,
  parameter int SRC_W = 3
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic             active_i,
  input logic             src_chg_i,
  input logic [SRC_W-1:0] src_i,
  input logic             req_i,
  input logic             valid_i
);
  a_r5_change_drops_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    src_chg_i |=> !valid_i);
  a_r5_change_blocks_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    src_chg_i |=> !req_i);
  a_r9_inactive_clears_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active_i |=> !valid_i);
  a_r9_inactive_no_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active_i |-> !req_i);
  a_r11_halted_no_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i |-> !req_i);
  a_r4_running_src_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> $stable(src_i));
  a_r10_valid_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && active_i && !src_chg_i) |=> valid_i);
  a_r3_src_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    32'(src_i) <= N_EXT);
endmodule

bind thermal_seq thermal_seq_chk #(.N_EXT(N_EXT), .SRC_W(SRC_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .start_i(ctrl.start), .active_i(active),
  .src_chg_i(src_chg), .src_i(src_o), .req_i(smp_req_o), .valid_i(valid_o)
);

// File: tb/thermal_seq_bench.sv
`timescale 1ns/1ps
module thermal_seq_bench;
  localparam int S  = 40;
  localparam int TB = 4;
  localparam int NV = 5;

  // ctrl word (start clear), avg word, samples a/b, expected src, latency, requests, mean
  localparam logic [31:0] V_CTRL [NV] = '{32'h0300_0004, 32'h8000_0004, 32'h8200_6044,
                                          32'h8100_2004, 32'hC100_4004};
  localparam int V_AVG [NV] = '{1, 2, 1, 0, 3};
  localparam int V_A   [NV] = '{100, 200, 1000, 5, 512};
  localparam int V_B   [NV] = '{107, 211, 3, 9, 513};
  localparam int V_SRC [NV] = '{0, 1, 4, 2, 0};
  localparam int V_LAT [NV] = '{104, 56, 56, 48, 104};
  localparam int V_NRQ [NV] = '{2, 4, 1, 1, 8};
  localparam int V_EXP [NV] = '{103, 205, 1000, 5, 512};

  logic        clk = 0, rst_n = 0, wr = 0, req_clr = 0, done = 0;
  logic [1:0]  addr = 0;
  logic [31:0] wdata = 0, rdata;
  logic [9:0]  cur_a = 0, cur_b = 0, smp;
  logic        req, valid;
  logic [2:0]  src;
  int unsigned req_cnt = 0;
  int          n_chk = 0, n_bad = 0;

  always #4 clk = ~clk;

  assign smp = req_cnt[0] ? cur_b : cur_a;
  always @(posedge clk)
    if (req_clr) req_cnt <= 0;
    else if (req) req_cnt <= req_cnt + 1;

  thermal_seq #(.N_EXT(4), .SETTLE_CYC(S), .TICK_BASE(TB), .ADDR_W(2)) u_thermal_seq (
    .clk_i(clk), .rst_ni(rst_n), .wr_i(wr), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .smp_data_i(smp), .smp_req_o(req), .src_o(src), .valid_o(valid)
  );

  task automatic check(input string tag, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [1:0] a, input logic [31:0] d, input logic clr);
    @(negedge clk); wr = 1; addr = a; wdata = d; req_clr = clr;
    @(negedge clk); wr = 0; req_clr = 0;
  endtask

  task automatic rd_reg(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; #1 d = rdata;
  endtask

  task automatic wait_valid(output int k, output int nreq);
    k = 0; nreq = 0;
    while (k < 5000) begin
      @(negedge clk); k++;
      if (valid) break;
      if (req) nreq++;
    end
  endtask

  task automatic count_req(input int cyc, output int nreq);
    nreq = 0;
    for (int i = 0; i < cyc; i++) begin
      @(negedge clk);
      if (req) nreq++;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    int k, nr;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    rd_reg(0, d); check("R1 ctrl", d, 0);
    rd_reg(1, d); check("R1 avg", d, 0);
    rd_reg(2, d); check("R1 status", d, 0);
    check("R1 src", src, 0);
    check("R1 valid", valid, 0);
    check("R1 req", req, 0);

    for (int v = 0; v < NV; v++) begin
      cur_a = 10'(V_A[v]); cur_b = 10'(V_B[v]);
      wr_reg(0, 32'h0000_0004, 0);
      wr_reg(0, V_CTRL[v], 0);
      check("R5 valid drop", valid, 0);
      check("R3 src select", src, V_SRC[v]);
      wr_reg(1, 32'(V_AVG[v]), 0);
      rd_reg(1, d); check("R2 avg readback", d, V_AVG[v]);
      wr_reg(0, V_CTRL[v] | 32'h1, 1);
      wait_valid(k, nr);
      check("R6 latency", k, V_LAT[v]);
      check("R8 request count", nr, V_NRQ[v]);
      rd_reg(2, d); check("R7 mean", d, 32'h400 | 32'(V_EXP[v]));
      rd_reg(0, d); check("R2 ctrl readback", d, V_CTRL[v] | 32'h1);
    end

    // R11 halt keeps valid
    wr_reg(0, 32'hC100_4004, 0);
    count_req(20, nr);
    check("R11 no req", nr, 0);
    check("R11 valid held", valid, 1);
    // R10 equal source, other mode encoding
    wr_reg(0, 32'h0100_0004, 0);
    check("R10 valid kept", valid, 1);
    rd_reg(0, d); check("R10 readback", d, 32'h0100_0004);
    wr_reg(0, 32'h0100_0005, 0);
    k = 0;
    while (k < 200) begin
      @(negedge clk); k++;
      if (req) break;
    end
    check("R10 no resettle", k, 7);
    check("R10 valid run", valid, 1);
    // R4 source write while running
    wr_reg(0, 32'h8100_2005, 0);
    check("R4 src hold", src, 0);
    check("R4 valid", valid, 1);
    rd_reg(0, d); check("R4 readback", d, 32'h0100_0005);
    // R11 halt holds sample
    wr_reg(0, 32'h0100_0004, 0);
    count_req(40, nr);
    check("R11 no req halted", nr, 0);
    rd_reg(2, d); check("R11 sample held", d, 32'h400 | 32'd512);
    // R3 channel out of range
    wr_reg(0, 32'h8000_8004, 0);
    check("R3 range src", src, 0);
    check("R3 range valid", valid, 1);
    rd_reg(0, d); check("R3 range readback", d, 32'h0000_0004);
    // R9 sensor reset
    wr_reg(0, 32'h0100_0007, 0);
    @(negedge clk);
    check("R9 reset valid", valid, 0);
    count_req(40, nr);
    check("R9 reset no req", nr, 0);
    cur_a = 10'd60; cur_b = 10'd61;
    wr_reg(0, 32'h0100_0005, 1);
    wait_valid(k, nr);
    check("R9 relatency", k, S + 8 * 8);
    check("R9 req count", nr, 8);
    rd_reg(2, d); check("R9 mean", d, 32'h400 | 32'd60);
    // R9 enable low
    wr_reg(0, 32'h0100_0001, 0);
    @(negedge clk);
    check("R9 disable valid", valid, 0);
    count_req(40, nr);
    check("R9 disable no req", nr, 0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule